// File: doc/BRIEF.md
# Masked Vector Element Execution Unit

This unit carries out one element-wise vector instruction at a time against an external vector register file. It handles two data operations, an add of two source vectors and a copy of one source vector, plus two operations on its internal per-element mask: one turns every mask bit on, and one sets each bit from a signed greater-than compare of an element against a scalar. A data operation writes the destination element only where the mask bit is on. Elements at or beyond the active vector length are never touched.

An instruction is presented with a one-cycle `start` pulse together with its opcode, register numbers, scalar and vector length. The unit reads source elements through a combinational read port, emits results on a registered write port one element per cycle, and answers with a one-cycle `done` pulse. A parameter picks the walking policy. The full-walk policy spends one cycle on every element below the vector length and drops the write where the mask bit is off. The compressed policy scans the mask and spends cycles only on enabled elements.

Top module: `vmask_exec_unit`

## Requirements
- R1: After reset `done` and `rf_we` are low and every mask bit is on, so a data operation issued first writes every element below the vector length.
- R2: Opcode 2'b00 (add) writes element i of register `vd` with the sum modulo 2^32 of element i of `vs1` and element i of `vs2`. The values are read before any write of the same instruction, so `vd` may equal a source.
- R3: Opcode 2'b01 (copy) writes element i of `vd` with element i of `vs1`.
- R4: An element whose mask bit is off is not written, and its destination keeps its previous value.
- R5: Elements with index at or above the vector length are never written. A `vl` value above the element count is treated as the element count.
- R6: In full-walk mode (COMPRESSED=0), writes come in ascending index order, and `done` rises VL+2 clock edges after the edge that samples `start`. With VL=0 it rises after one edge.
- R7: In compressed mode (COMPRESSED=1), the enabled elements are written in ascending order on consecutive cycles, and `done` rises P+2 edges after the sampling edge, where P is the number of enabled elements below VL. With P=0, `done` rises after one edge.
- R8: Opcode 2'b10 turns every mask bit on, makes no write, and raises `done` after one edge.
- R9: Opcode 2'b11 sets mask bit i, for i below VL, exactly when element i of `vs1` is greater than `scalar` as signed 32-bit values, and clears every bit at or above VL. It makes no write. `done` rises VL+2 edges after the sampling edge in both modes, or after one edge when VL=0.
- R10: `done` is high for a single cycle per instruction. A `start` that arrives while an instruction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Instruction issue pulse |
| op | input | 2 | Opcode: 00 add, 01 copy, 10 mask all on, 11 mask from compare |
| vd | input | 3 | Destination register number |
| vs1 | input | 3 | First source register number |
| vs2 | input | 3 | Second source register number |
| scalar | input | 32 | Scalar operand for the compare |
| vl | input | 7 | Vector length, sampled with start |
| done | output | 1 | One-cycle completion pulse |
| rd_reg_a | output | 3 | Read port A register number |
| rd_reg_b | output | 3 | Read port B register number |
| rd_elem | output | 6 | Element index shared by both read ports |
| rd_data_a | input | 32 | Read port A data, combinational |
| rd_data_b | input | 32 | Read port B data, combinational |
| rf_we | output | 1 | Register file write enable |
| rf_wreg | output | 3 | Write register number |
| rf_welem | output | 6 | Write element index |
| rf_wdata | output | 32 | Write data |

## Verification
Two instances, one per walking policy, receive the same instruction stream, so a single expected write sequence checks both while their latencies are checked apart. The mask patterns are all on, all off, mixed from a compare at zero, and cut short at a partial length by a compare at a negative scalar. These separate a unit that honours the mask from one that writes everything, and a compressed walk from a full walk. Short, zero and oversize vector lengths, and an add whose destination is also a source, test the bounds and the read-before-write order. A second start issued mid-instruction carries a compare that would clear the mask, so if it were accepted the next add would show it.

// File: rtl/vmx_pkg.sv
// Package: shared opcode and control-state types for the masked vector unit.
// Assumes: opcode values are fixed by the instruction encoding seen at the ports.
package vmx_pkg;

    typedef enum logic [1:0] {
        VOP_ADD  = 2'b00,
        VOP_COPY = 2'b01,
        VOP_MSET = 2'b10,
        VOP_MGT  = 2'b11
    } vop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIN  = 2'b10
    } vstate_e;

endpackage

// File: rtl/vmx_lane_alu.sv
// Module: element datapath. Forms the add or copy result and the signed
// greater-than flag for one element.
// Assumes: purely combinational; the caller registers what it needs.
module vmx_lane_alu #(
    parameter int ELEM_W = 32
) (
    input  vmx_pkg::vop_e       op,
    input  logic [ELEM_W-1:0]   src_a,
    input  logic [ELEM_W-1:0]   src_b,
    input  logic [ELEM_W-1:0]   scalar,
    output logic [ELEM_W-1:0]   result,
    output logic                gt
);
    import vmx_pkg::*;

    // Select add or pass-through of the first source.
    always_comb begin
        if (op == VOP_ADD) result = src_a + src_b;
        else               result = src_a;
    end

    // Signed comparison of the element against the scalar.
    always_comb gt = $signed(src_a) > $signed(scalar);

endmodule

// File: rtl/vmx_mask_reg.sv
// Module: per-element mask register. Can be set to all ones, cleared, or
// updated one bit per cycle.
// Assumes: set_all and clear_all are never high together with bit_we.
module vmx_mask_reg #(
    parameter int NUM_ELEM = 64,
    localparam int IW = $clog2(NUM_ELEM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_all,
    input  logic                clear_all,
    input  logic                bit_we,
    input  logic [IW-1:0]       bit_idx,
    input  logic                bit_val,
    output logic [NUM_ELEM-1:0] mask
);

    // Mask storage; resets to all enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask <= '1;
        else if (set_all)   mask <= '1;
        else if (clear_all) mask <= '0;
        else if (bit_we)    mask[bit_idx] <= bit_val;
    end

    p_set_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_all |=> (&mask));
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_all && !set_all) |=> (mask == '0));

endmodule

// File: rtl/vmx_elem_seq.sv
// Module: element sequencer. Holds a pending-element vector and steps
// through its set bits from lowest to highest, one per step.
// COMPRESSED=0 loads every index below VL; COMPRESSED=1 loads only the
// enabled ones, unless walk_all asks for every index.
// Assumes: load and step are never high together.
module vmx_elem_seq #(
    parameter int NUM_ELEM   = 64,
    parameter bit COMPRESSED = 1'b0,
    localparam int IW = $clog2(NUM_ELEM),
    localparam int LW = $clog2(NUM_ELEM + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                walk_all,
    input  logic [NUM_ELEM-1:0] mask,
    input  logic [LW-1:0]       vl_eff,
    input  logic                step,
    output logic                load_empty,
    output logic                busy,
    output logic [IW-1:0]       cur_idx,
    output logic                cur_last,
    output logic                cur_en
);

    logic [NUM_ELEM-1:0] vl_mask;
    logic [NUM_ELEM-1:0] load_vec;
    logic [NUM_ELEM-1:0] pend;
    logic [NUM_ELEM-1:0] pick;
    logic                walk_all_q;

    // Thermometer of the indices below the vector length.
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_vlm
        assign vl_mask[g] = (LW'(g) < vl_eff);
    end

    // The policy decides which indices are queued.
    if (COMPRESSED) begin : g_cmp
        assign load_vec = walk_all ? vl_mask : (vl_mask & mask);
    end else begin : g_full
        assign load_vec = vl_mask;
    end

    assign load_empty = (load_vec == '0);
    assign busy       = (pend != '0);

    // Isolate the lowest pending index.
    always_comb pick = pend & (~pend + 1'b1);

    // Encode the lowest pending index.
    always_comb begin
        cur_idx = '0;
        for (int i = NUM_ELEM - 1; i >= 0; i--)
            if (pend[i]) cur_idx = IW'(i);
    end

    assign cur_last = ((pend & ~pick) == '0);

    // Full walk gates by mask; compressed walk only visits enabled indices.
    always_comb begin
        if (COMPRESSED) cur_en = 1'b1;
        else            cur_en = walk_all_q | mask[cur_idx];
    end

    // Pending vector: load on issue, retire the lowest bit on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= '0;
        else if (load) pend <= load_vec;
        else if (step) pend <= pend & ~pick;
    end

    // Remember whether this walk ignores the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)    walk_all_q <= 1'b0;
        else if (load) walk_all_q <= walk_all;
    end

    p_cur_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pend[cur_idx]);
    p_step_retires_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && busy && !load) |=> ($countones(pend) == $countones($past(pend)) - 1));

endmodule

// File: rtl/vmask_exec_unit.sv
// Module: top of the masked vector element execution unit. Accepts one
// instruction per start pulse, drives register-file reads and registered
// writes, maintains the mask, and pulses done at the end.
// Assumes: the register file returns read data in the same cycle as the
// address, and accepts the registered write one cycle after issue.
module vmask_exec_unit #(
    parameter int NUM_ELEM   = 64,
    parameter int ELEM_W     = 32,
    parameter int NUM_VREG   = 8,
    parameter bit COMPRESSED = 1'b0,
    localparam int IW = $clog2(NUM_ELEM),
    localparam int LW = $clog2(NUM_ELEM + 1),
    localparam int RW = $clog2(NUM_VREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [RW-1:0]     vd,
    input  logic [RW-1:0]     vs1,
    input  logic [RW-1:0]     vs2,
    input  logic [ELEM_W-1:0] scalar,
    input  logic [LW-1:0]     vl,
    output logic              done,
    output logic [RW-1:0]     rd_reg_a,
    output logic [RW-1:0]     rd_reg_b,
    output logic [IW-1:0]     rd_elem,
    input  logic [ELEM_W-1:0] rd_data_a,
    input  logic [ELEM_W-1:0] rd_data_b,
    output logic              rf_we,
    output logic [RW-1:0]     rf_wreg,
    output logic [IW-1:0]     rf_welem,
    output logic [ELEM_W-1:0] rf_wdata
);
    import vmx_pkg::*;

    vstate_e           state;
    vop_e              op_in;
    vop_e              op_q;
    logic [RW-1:0]     vd_q, vs1_q, vs2_q;
    logic [ELEM_W-1:0] scalar_q;
    logic [LW-1:0]     vl_eff, vl_q;
    logic              accept;
    logic              walk_op;
    logic              seq_load;
    logic              seq_empty, seq_busy;
    logic [IW-1:0]     cur_idx;
    logic              cur_last, cur_en;
    logic              running;
    logic [NUM_ELEM-1:0] mask;
    logic [ELEM_W-1:0] alu_res;
    logic              alu_gt;

    assign op_in    = vop_e'(op);
    assign accept   = start && (state == ST_IDLE);
    assign walk_op  = (op_in != VOP_MSET);
    assign seq_load = accept && walk_op;
    assign running  = (state == ST_RUN);
    assign vl_eff   = (vl > LW'(NUM_ELEM)) ? LW'(NUM_ELEM) : vl;

    assign rd_reg_a = vs1_q;
    assign rd_reg_b = vs2_q;
    assign rd_elem  = cur_idx;

    vmx_elem_seq #(.NUM_ELEM(NUM_ELEM), .COMPRESSED(COMPRESSED)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (seq_load),
        .walk_all   (op_in == VOP_MGT),
        .mask       (mask),
        .vl_eff     (vl_eff),
        .step       (running),
        .load_empty (seq_empty),
        .busy       (seq_busy),
        .cur_idx    (cur_idx),
        .cur_last   (cur_last),
        .cur_en     (cur_en)
    );

    vmx_mask_reg #(.NUM_ELEM(NUM_ELEM)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_all   (accept && op_in == VOP_MSET),
        .clear_all (accept && op_in == VOP_MGT),
        .bit_we    (running && op_q == VOP_MGT),
        .bit_idx   (cur_idx),
        .bit_val   (alu_gt),
        .mask      (mask)
    );

    vmx_lane_alu #(.ELEM_W(ELEM_W)) u_alu (
        .op     (op_q),
        .src_a  (rd_data_a),
        .src_b  (rd_data_b),
        .scalar (scalar_q),
        .result (alu_res),
        .gt     (alu_gt)
    );

    // Latch the instruction fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= VOP_ADD;
            vd_q     <= '0;
            vs1_q    <= '0;
            vs2_q    <= '0;
            scalar_q <= '0;
            vl_q     <= '0;
        end else if (accept) begin
            op_q     <= op_in;
            vd_q     <= vd;
            vs1_q    <= vs1;
            vs2_q    <= vs2;
            scalar_q <= scalar;
            vl_q     <= vl_eff;
        end
    end

    // Control sequence: idle, walk the elements, then one finishing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else begin
            case (state)
                ST_IDLE: if (seq_load && !seq_empty) state <= ST_RUN;
                ST_RUN:  if (cur_last) state <= ST_FIN;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse: right after an empty or mask-only instruction, or after the finishing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (accept && (!walk_op || seq_empty)) || (state == ST_FIN);
    end

    // Registered write port for enabled data elements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we    <= 1'b0;
            rf_wreg  <= '0;
            rf_welem <= '0;
            rf_wdata <= '0;
        end else begin
            rf_we <= running && cur_en && (op_q == VOP_ADD || op_q == VOP_COPY);
            if (running) begin
                rf_wreg  <= vd_q;
                rf_welem <= cur_idx;
                rf_wdata <= alu_res;
            end
        end
    end

    p_we_below_vl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (LW'(rf_welem) < vl_q));
    p_we_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> mask[rf_welem]);
    p_run_tracks_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> seq_busy);
    p_busy_holds_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != ST_IDLE) |=> ($stable(op_q) && $stable(vd_q) && $stable(scalar_q)));
    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == ST_IDLE));

endmodule

// File: tb/test_vmask_exec_unit.sv
// Bench: drives two instances (full walk and compressed) with one instruction
// stream; a driver pushes expected writes into per-instance queues and a
// monitor pops and compares each write as it appears.
module test_vmask_exec_unit;

    localparam int NE = 64;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [2:0]  vd = '0, vs1 = '0, vs2 = '0;
    logic [31:0] scalar = '0;
    logic [6:0]  vl = '0;

    logic        done0, done1, we0, we1;
    logic [2:0]  ra0, rb0, ra1, rb1, wr0, wr1;
    logic [5:0]  re0, re1, we_el0, we_el1;
    logic [31:0] da0, db0, da1, db1, wd0, wd1;

    logic [31:0] rf0 [NR][NE];
    logic [31:0] rf1 [NR][NE];
    logic [31:0] exp_rf [NR][NE];
    logic [63:0] mask_m;
    logic [40:0] q0[$];
    logic [40:0] q1[$];

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign da0 = rf0[ra0][re0];
    assign db0 = rf0[rb0][re0];
    assign da1 = rf1[ra1][re1];
    assign db1 = rf1[rb1][re1];

    vmask_exec_unit #(.COMPRESSED(1'b0)) i_vmask_exec_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vd(vd), .vs1(vs1),
        .vs2(vs2), .scalar(scalar), .vl(vl), .done(done0), .rd_reg_a(ra0),
        .rd_reg_b(rb0), .rd_elem(re0), .rd_data_a(da0), .rd_data_b(db0),
        .rf_we(we0), .rf_wreg(wr0), .rf_welem(we_el0), .rf_wdata(wd0));

    vmask_exec_unit #(.COMPRESSED(1'b1)) i_vmask_exec_unit_cmp (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vd(vd), .vs1(vs1),
        .vs2(vs2), .scalar(scalar), .vl(vl), .done(done1), .rd_reg_a(ra1),
        .rd_reg_b(rb1), .rd_elem(re1), .rd_data_a(da1), .rd_data_b(db1),
        .rf_we(we1), .rf_wreg(wr1), .rf_welem(we_el1), .rf_wdata(wd1));

    function automatic logic [31:0] init_val(input int r, input int e);
        return 32'((r * 64 + e + 1) * 32'h9E37_79B1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Monitor: pop the expected write for each observed write and update the register model.
    task automatic mon_one(input int k, input logic [2:0] r, input logic [5:0] e,
                           input logic [31:0] d);
        logic [40:0] got, expv;
        got = {r, e, d};
        if ((k == 0 ? q0.size() : q1.size()) == 0) begin
            check(1'b0, "R4", $sformatf("unexpected write inst%0d", k), 64'(got), 64'h0);
        end else begin
            expv = (k == 0) ? q0.pop_front() : q1.pop_front();
            check(got == expv, "R2", $sformatf("write item inst%0d", k), 64'(got), 64'(expv));
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NR; r++)
                for (int e = 0; e < NE; e++) begin
                    rf0[r][e] = init_val(r, e);
                    rf1[r][e] = init_val(r, e);
                end
        end else begin
            if (we0) begin
                mon_one(0, wr0, we_el0, wd0);
                rf0[wr0][we_el0] = wd0;
            end
            if (we1) begin
                mon_one(1, wr1, we_el1, wd1);
                rf1[wr1][we_el1] = wd1;
            end
        end
    end

    // Driver: compute the expected writes and latencies, issue, then wait for done.
    task automatic run_op(input logic [1:0] o, input logic [2:0] d, input logic [2:0] s1,
                          input logic [2:0] s2, input logic [31:0] sc, input logic [6:0] len,
                          input string req, input bit poke);
        int vle, pc, lat_e0, lat_e1, lat0, lat1, n;
        logic [31:0] res [NE];
        vle = (len > 7'd64) ? 64 : int'(len);
        pc = 0;
        for (int i = 0; i < vle; i++) if (mask_m[i]) pc++;
        if (o == 2'b10) begin
            lat_e0 = 1; lat_e1 = 1;
            mask_m = '1;
        end else if (o == 2'b11) begin
            lat_e0 = (vle == 0) ? 1 : vle + 2; lat_e1 = lat_e0;
            for (int i = 0; i < NE; i++)
                mask_m[i] = (i < vle) && ($signed(exp_rf[s1][i]) > $signed(sc));
        end else begin
            lat_e0 = (vle == 0) ? 1 : vle + 2;
            lat_e1 = (pc == 0) ? 1 : pc + 2;
            for (int i = 0; i < NE; i++)
                res[i] = (o == 2'b00) ? exp_rf[s1][i] + exp_rf[s2][i] : exp_rf[s1][i];
            for (int i = 0; i < vle; i++)
                if (mask_m[i]) begin
                    q0.push_back({d, 6'(i), res[i]});
                    q1.push_back({d, 6'(i), res[i]});
                    exp_rf[d][i] = res[i];
                end
        end
        op = o; vd = d; vs1 = s1; vs2 = s2; scalar = sc; vl = len;
        start = 1'b1;
        n = 0; lat0 = 0; lat1 = 0;
        while (n < 300) begin
            @(posedge clk); @(negedge clk);
            n++;
            if (n == 1) start = 1'b0;
            if (poke && n == 2) begin
                op = 2'b11; scalar = 32'h7FFF_FFFF; vl = 7'd64; start = 1'b1;
            end
            if (poke && n == 3) start = 1'b0;
            if (lat0 != 0 && n == lat0 + 1)
                check(!done0, "R10", "done pulse width inst0", 64'(done0), 64'h0);
            if (lat1 != 0 && n == lat1 + 1)
                check(!done1, "R10", "done pulse width inst1", 64'(done1), 64'h0);
            if (done0 && lat0 == 0) lat0 = n;
            if (done1 && lat1 == 0) lat1 = n;
            if (lat0 != 0 && lat1 != 0 && n > lat0 && n > lat1) break;
        end
        check(lat0 == lat_e0, (o == 2'b11) ? "R9" : (o == 2'b10) ? "R8" : "R6",
              {req, " latency full walk"}, 64'(lat0), 64'(lat_e0));
        check(lat1 == lat_e1, (o == 2'b11) ? "R9" : (o == 2'b10) ? "R8" : "R7",
              {req, " latency compressed"}, 64'(lat1), 64'(lat_e1));
        check(q0.size() == 0, req, "missing writes inst0", 64'(q0.size()), 64'h0);
        check(q1.size() == 0, req, "missing writes inst1", 64'(q1.size()), 64'h0);
        q0.delete(); q1.delete();
        for (int k = 0; k < 2; k++) begin
            int bad;
            logic [31:0] av, ev;
            bad = -1; av = '0; ev = '0;
            for (int e = NE - 1; e >= 0; e--) begin
                logic [31:0] v;
                v = (k == 0) ? rf0[d][e] : rf1[d][e];
                if (v != exp_rf[d][e]) begin bad = e; av = v; ev = exp_rf[d][e]; end
            end
            check(bad < 0, (bad >= vle) ? "R5" : "R4",
                  $sformatf("%s vreg%0d contents inst%0d elem %0d", req, d, k, bad),
                  64'(av), 64'(ev));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        mask_m = '1;
        for (int r = 0; r < NR; r++)
            for (int e = 0; e < NE; e++) exp_rf[r][e] = init_val(r, e);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet in reset and right after it.
        check(!done0 && !done1, "R1", "done in reset", 64'({done0, done1}), 64'h0);
        check(!we0 && !we1, "R1", "write enable in reset", 64'({we0, we1}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done0 && !done1 && !we0 && !we1, "R1", "idle after reset",
              64'({done0, done1, we0, we1}), 64'h0);
        // R1 R2: add under the reset mask writes every element.
        run_op(2'b00, 3'd2, 3'd0, 3'd1, 32'h0, 7'd64, "R2", 1'b0);
        // R9: compare against zero gives a mixed mask.
        run_op(2'b11, 3'd0, 3'd3, 3'd0, 32'h0, 7'd64, "R9", 1'b0);
        // R3 R4: copy under the mixed mask.
        run_op(2'b01, 3'd4, 3'd5, 3'd0, 32'h0, 7'd64, "R3", 1'b0);
        // R5: short length with destination aliasing a source.
        run_op(2'b00, 3'd6, 3'd6, 3'd0, 32'h0, 7'd10, "R5", 1'b0);
        // R5: oversize length clamps to the element count.
        run_op(2'b01, 3'd7, 3'd1, 3'd0, 32'h0, 7'd100, "R5", 1'b0);
        // R9 R7: no element beats the largest positive scalar, then an add writes nothing.
        run_op(2'b11, 3'd0, 3'd2, 3'd0, 32'h7FFF_FFFF, 7'd64, "R9", 1'b0);
        run_op(2'b00, 3'd3, 3'd0, 3'd1, 32'h0, 7'd64, "R7", 1'b0);
        // R8: mask all on, then a short add writes all of it.
        run_op(2'b10, 3'd0, 3'd0, 3'd0, 32'h0, 7'd0, "R8", 1'b0);
        run_op(2'b00, 3'd5, 3'd1, 3'd2, 32'h0, 7'd5, "R8", 1'b0);
        // R9: negative scalar with partial length clears the upper bits.
        run_op(2'b11, 3'd0, 3'd4, 3'd0, 32'hFFFF_FFFB, 7'd40, "R9", 1'b0);
        run_op(2'b01, 3'd1, 3'd3, 3'd0, 32'h0, 7'd64, "R9", 1'b0);
        // R10: a clearing compare issued mid-instruction must be ignored.
        run_op(2'b10, 3'd0, 3'd0, 3'd0, 32'h0, 7'd0, "R10", 1'b0);
        run_op(2'b01, 3'd5, 3'd0, 3'd0, 32'h0, 7'd30, "R10", 1'b1);
        run_op(2'b00, 3'd6, 3'd2, 3'd7, 32'h0, 7'd64, "R10", 1'b0);
        // R6 R7 R9: zero-length compare clears the whole mask; copy then writes nothing.
        run_op(2'b11, 3'd0, 3'd1, 3'd0, 32'h8000_0000, 7'd0, "R9", 1'b0);
        run_op(2'b01, 3'd2, 3'd4, 3'd0, 32'h0, 7'd64, "R6", 1'b0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule